// File: doc/BRIEF.md
# Mode-Selectable Receive Deserializer

This block sits behind a clock-recovery stage. It takes the recovered NRZ bit stream, one bit per cycle of `bit_stb`, and presents it in one of three formats chosen by two static controls. In serial format each bit and a matching clock pulse are forwarded directly. In the two parallel formats the bits are packed most-significant-first into 4-bit or 8-bit words. Each finished word comes with a one-cycle valid pulse and a word clock that runs at one quarter or one eighth of the bit rate.

The mode controls are meant to be static. They can still change at run time, and any change of the decoded format realigns the packer, so the next word starts cleanly on its top lane. All state uses one clock domain and a synchronous active-high reset.

Top module: `rx_deser_top`

## Requirements
- R1: `par_sel`=0 selects serial format. `par_sel`=1 with `wide_sel`=1 selects 8-bit words. `par_sel`=1 with `wide_sel`=0 selects 4-bit words. In both parallel formats `ser_dat` and `ser_clk` stay low.
- R2: In serial format, `ser_clk` is high for exactly the cycle after each `bit_stb`, and `ser_dat` holds the bit taken at the latest strobe. `word_vld`, `wclk_out` and `word_out` stay zero.
- R3: In serial format `wide_sel` has no effect. Toggling it, even in a strobe cycle, neither drops that bit nor disturbs the serial outputs.
- R4: In the parallel formats, the first bit of a word lands on lane 7 (8-bit) or lane 3 (4-bit), and the last bit lands on lane 0.
- R5: In 4-bit format, lanes 7 to 4 of `word_out` are always low, including right after a switch from 8-bit format.
- R6: `word_vld` is high for one clock cycle: the cycle after the strobe that carries the last bit of a word. `word_out` changes in that same cycle and then holds until the next word completes.
- R7: `wclk_out` rises with the strobe that completes a word and falls after half a word of further strobes. Its period is 8 strobes in 8-bit format and 4 in 4-bit format. It is low in serial format and before the first word after a realignment.
- R8: A change of the decoded format clears the bit counter, the partial word, `word_out` and `wclk_out`. A bit strobed in the change cycle is discarded, and the next strobe starts a new word on the top lane.
- R9: Synchronous reset clears every output and all internal state to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Recovered serial bit |
| bit_stb | input | 1 | Bit-rate enable qualifying `bit_in` |
| par_sel | input | 1 | 1 = parallel formats, 0 = serial |
| wide_sel | input | 1 | In parallel: 1 = 8-bit words, 0 = 4-bit words |
| word_out | output | 8 | Packed word, MSB first |
| word_vld | output | 1 | One-cycle pulse when `word_out` updates |
| wclk_out | output | 1 | Divided word clock level |
| ser_dat | output | 1 | Serial data passthrough |
| ser_clk | output | 1 | Serial clock pulse passthrough |

## Verification
Two functions can collide in one cycle: a format change and a bit strobe. The bench drives them together in two ways. First, it switches from 8-bit to 4-bit format while strobing a bit. It expects that bit to be dropped, no valid pulse, cleared outputs, and the next four bits to form a word aligned on lane 3. Second, it toggles `wide_sel` in serial format during a strobe. Here the decoded format does not change, so the bit must come out on `ser_dat` with its `ser_clk` pulse as usual.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    typedef enum logic [1:0] {
        FMT_SER  = 2'd0,
        FMT_NIB  = 2'd1,
        FMT_BYTE = 2'd2
    } fmt_e;

    typedef struct packed {
        logic dat;
        logic clk;
    } ser_out_t;

    function automatic fmt_e decode_fmt(input logic par, input logic wide);
        if (!par) return FMT_SER;
        return wide ? FMT_BYTE : FMT_NIB;
    endfunction

endpackage

// File: rtl/rxd_mode_ctl.sv
module rxd_mode_ctl
    import rxd_pkg::*;
(
    input  logic clk,
    input  logic par_sel,
    input  logic wide_sel,
    output fmt_e fmt,
    output logic clr
);
    fmt_e fmt_q;

    assign fmt = decode_fmt(par_sel, wide_sel);

    always_ff @(posedge clk) begin
        fmt_q <= fmt;
    end

    assign clr = (fmt != fmt_q);
endmodule

// File: rtl/rxd_packer.sv
module rxd_packer
    import rxd_pkg::*;
#(
    parameter int WIDE_W   = 8,
    parameter int NARROW_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  fmt_e              fmt,
    input  logic              stb,
    input  logic              din,
    output logic [WIDE_W-1:0] word,
    output logic              vld,
    output logic              wclk
);
    localparam int CNT_W = $clog2(WIDE_W);

    logic [WIDE_W-2:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  last_idx;
    logic [CNT_W-1:0]  half_idx;
    logic [WIDE_W-1:0] full;
    logic [WIDE_W-1:0] lane_en;
    logic              active;

    assign active   = (fmt != FMT_SER);
    assign last_idx = (fmt == FMT_BYTE) ? CNT_W'(WIDE_W - 1)   : CNT_W'(NARROW_W - 1);
    assign half_idx = (fmt == FMT_BYTE) ? CNT_W'(WIDE_W/2 - 1) : CNT_W'(NARROW_W/2 - 1);
    assign full     = {sh, din};

    for (genvar g = 0; g < WIDE_W; g++) begin : g_lane
        if (g < NARROW_W) begin : g_low
            assign lane_en[g] = 1'b1;
        end else begin : g_high
            assign lane_en[g] = (fmt == FMT_BYTE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh   <= '0;
            cnt  <= '0;
            word <= '0;
            vld  <= 1'b0;
            wclk <= 1'b0;
        end else begin
            vld <= 1'b0;
            if (active && stb) begin
                sh <= full[WIDE_W-2:0];
                if (cnt == last_idx) begin
                    cnt  <= '0;
                    word <= full & lane_en;
                    vld  <= 1'b1;
                    wclk <= 1'b1;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                    if (cnt == half_idx) wclk <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/rxd_serial_path.sv
module rxd_serial_path
    import rxd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  fmt_e     fmt,
    input  logic     stb,
    input  logic     din,
    output ser_out_t so
);
    always_ff @(posedge clk) begin
        if (rst || clr || fmt != FMT_SER) begin
            so <= '0;
        end else begin
            so.clk <= stb;
            if (stb) so.dat <= din;
        end
    end
endmodule

// File: rtl/rx_deser_top.sv
module rx_deser_top
    import rxd_pkg::*;
#(
    parameter int WIDE_W   = 8,
    parameter int NARROW_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_in,
    input  logic              bit_stb,
    input  logic              par_sel,
    input  logic              wide_sel,
    output logic [WIDE_W-1:0] word_out,
    output logic              word_vld,
    output logic              wclk_out,
    output logic              ser_dat,
    output logic              ser_clk
);
    fmt_e     fmt;
    logic     clr;
    ser_out_t so;

    rxd_mode_ctl u_mode (
        .clk      (clk),
        .par_sel  (par_sel),
        .wide_sel (wide_sel),
        .fmt      (fmt),
        .clr      (clr)
    );

    rxd_packer #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_pack (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .fmt  (fmt),
        .stb  (bit_stb),
        .din  (bit_in),
        .word (word_out),
        .vld  (word_vld),
        .wclk (wclk_out)
    );

    rxd_serial_path u_ser (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .fmt (fmt),
        .stb (bit_stb),
        .din (bit_in),
        .so  (so)
    );

    assign ser_dat = so.dat;
    assign ser_clk = so.clk;
endmodule

// File: rtl/rx_deser_chk.sv
module rx_deser_chk #(
    parameter int WIDE_W   = 8,
    parameter int NARROW_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bit_stb,
    input logic              par_sel,
    input logic              wide_sel,
    input logic [WIDE_W-1:0] word_out,
    input logic              word_vld,
    input logic              wclk_out,
    input logic              ser_dat,
    input logic              ser_clk
);
    AST_VLD_FROM_PAR_STB: assert property (@(posedge clk) disable iff (rst)
        word_vld |-> ($past(par_sel) && $past(bit_stb)));                         // R6
    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        word_vld |=> !word_vld);                                                   // R6
    AST_NIB_UPPER_LOW: assert property (@(posedge clk) disable iff (rst)
        (par_sel && !wide_sel && $past(par_sel) && !$past(wide_sel))
        |-> (word_out[WIDE_W-1:NARROW_W] == '0));                                  // R5
    AST_PAR_SER_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(par_sel) |-> (!ser_clk && !ser_dat));                                // R1
    AST_SER_NO_WORD: assert property (@(posedge clk) disable iff (rst)
        !$past(par_sel) |-> (!wclk_out && !word_vld));                             // R2
    AST_SER_CLK_TRACK: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(par_sel) && !$past(par_sel, 2))
        |-> (ser_clk == $past(bit_stb)));                                          // R2
endmodule

bind rx_deser_top rx_deser_chk #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_stb  (bit_stb),
    .par_sel  (par_sel),
    .wide_sel (wide_sel),
    .word_out (word_out),
    .word_vld (word_vld),
    .wclk_out (wclk_out),
    .ser_dat  (ser_dat),
    .ser_clk  (ser_clk)
);

// File: tb/tb_rx_deser_top.sv
module tb_rx_deser_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_in = 1'b0;
    logic       bit_stb = 1'b0;
    logic       par_sel = 1'b0;
    logic       wide_sel = 1'b0;
    logic [7:0] word_out;
    logic       word_vld, wclk_out, ser_dat, ser_clk;

    int errors = 0;
    int checks = 0;

    // reference model state
    bit m_par = 0, m_wide = 0;
    int pos = 0, acc = 0, exp_word = 0, exp_wclk = 0, last_ser = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_deser_top dut (
        .clk(clk), .rst(rst), .bit_in(bit_in), .bit_stb(bit_stb),
        .par_sel(par_sel), .wide_sel(wide_sel), .word_out(word_out),
        .word_vld(word_vld), .wclk_out(wclk_out), .ser_dat(ser_dat), .ser_clk(ser_clk)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        pos = 0; acc = 0; exp_word = 0; exp_wclk = 0; last_ser = 0;
    endtask

    task automatic check_all_zero(input string req);
        chk(req, "word_out", int'(word_out), 0);
        chk(req, "word_vld", int'(word_vld), 0);
        chk(req, "wclk_out", int'(wclk_out), 0);
        chk(req, "ser_dat",  int'(ser_dat), 0);
        chk(req, "ser_clk",  int'(ser_clk), 0);
    endtask

    // one strobe then sampled outputs at the next falling edge
    task automatic strobe(input bit b);
        int n;
        bit_in = b; bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0;
        if (!m_par) begin
            last_ser = b;
            chk("R2", "ser_clk pulse", int'(ser_clk), 1);
            chk("R2", "ser_dat", int'(ser_dat), b);
            chk("R2", "no word_vld", int'(word_vld), 0);
            chk("R2", "wclk low", int'(wclk_out), 0);
            chk("R2", "word zero", int'(word_out), 0);
        end else begin
            n = m_wide ? 8 : 4;
            acc = ((acc << 1) | b) & ((1 << n) - 1);
            if (pos == n - 1) begin
                exp_word = acc; exp_wclk = 1; pos = 0; acc = 0;
                chk("R6", "word_vld at completion", int'(word_vld), 1);
                chk("R4", "word MSB first", int'(word_out), exp_word);
            end else begin
                if (pos == n/2 - 1) exp_wclk = 0;
                pos++;
                chk("R6", "word_vld mid-word", int'(word_vld), 0);
                chk("R6", "word held", int'(word_out), exp_word);
            end
            chk("R7", "wclk_out", int'(wclk_out), exp_wclk);
            chk("R1", "ser quiet", int'({ser_dat, ser_clk}), 0);
            if (!m_wide) chk("R5", "upper lanes", int'(word_out[7:4]), 0);
        end
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            chk("R6", "idle word_vld", int'(word_vld), 0);
            chk("R6", "idle word held", int'(word_out), exp_word);
            chk("R7", "idle wclk", int'(wclk_out), exp_wclk);
            chk("R2", "idle ser_clk", int'(ser_clk), 0);
            chk("R2", "idle ser_dat", int'(ser_dat), m_par ? 0 : last_ser);
        end
    endtask

    task automatic set_mode(input bit p, input bit w, input bit with_stb, input bit b);
        bit changed;
        changed = (p != m_par) || (p && (w != m_wide));
        par_sel = p; wide_sel = w;
        bit_in = b; bit_stb = with_stb;
        @(negedge clk);
        bit_stb = 1'b0;
        m_par = p; m_wide = w;
        if (changed) begin
            model_clear();
            check_all_zero("R8");
        end else if (with_stb && !p) begin
            last_ser = b;
            chk("R3", "ser_clk kept", int'(ser_clk), 1);
            chk("R3", "ser_dat kept", int'(ser_dat), b);
        end
    endtask

    task automatic send_word(input int v, input int n, input int gap);
        for (int i = n - 1; i >= 0; i--) begin
            strobe(v[i]);
            if (gap > 0) idle(gap);
        end
    endtask

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all_zero("R9");

        // serial passthrough with varied gaps
        for (int i = 0; i < 16; i++) begin
            strobe(((i * 5) >> 1) & 1);
            idle(i % 3);
        end
        // wide_sel toggled in serial mode during a strobe
        set_mode(1'b0, 1'b1, 1'b1, 1'b1);
        idle(1);
        set_mode(1'b0, 1'b0, 1'b1, 1'b0);
        idle(1);
        strobe(1'b1);
        idle(2);

        // 8-bit sweep of every value, gaps 0..2
        set_mode(1'b1, 1'b1, 1'b0, 1'b0);
        for (int v = 0; v < 256; v++) send_word(v, 8, v % 3);

        // 8-bit -> 4-bit after a full word: upper lanes cleared
        send_word(8'hFF, 8, 0);
        set_mode(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R5", "upper lanes after switch", int'(word_out[7:4]), 0);
        for (int r = 0; r < 2; r++)
            for (int v = 0; v < 16; v++) send_word(v, 4, r);

        // format change colliding with a strobe mid-word
        set_mode(1'b1, 1'b1, 1'b0, 1'b0);
        send_word(8'h1F, 5, 0);
        set_mode(1'b1, 1'b0, 1'b1, 1'b1);
        chk("R8", "strobe dropped no vld", int'(word_vld), 0);
        send_word(4'hA, 4, 0);
        chk("R8", "realigned nibble", int'(word_out), 8'h0A);
        idle(2);

        // parallel -> serial clears word outputs
        set_mode(1'b0, 1'b1, 1'b0, 1'b0);
        strobe(1'b1);
        idle(1);

        // mid-word synchronous reset
        set_mode(1'b1, 1'b1, 1'b0, 1'b0);
        send_word(8'hE0, 8, 0);
        send_word(8'h07, 3, 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_clear();
        check_all_zero("R9");
        send_word(8'h81, 8, 1);
        chk("R9", "aligned after reset", int'(word_out), 8'h81);
        idle(3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule